// File: doc/BRIEF.md
# HDB3 Receive Decoder with Violation Alarm

This block is the digital back end of a 2.048 Mbit/s receive path. It gets the recovered clock and two recovered rail bits per symbol: a positive mark, a negative mark, or neither. In single-rail mode it merges the rails into unipolar NRZ data. It can also undo HDB3 zero substitution and report line-code errors on a violation output. In dual-rail mode it passes the two rails through unchanged, with an optional active-low polarity that also inverts the clock output.

Two overrides sit at the terminal-side outputs. An all-ones alarm control replaces the data with marks. An active-low alarm-test input forces the violation output high and leaves the data alone. Rail data runs through a delay line as deep as the substitution code, so every data mode has the same latency. The violation output is a one-cycle registered pulse.

Top module: `hdb3_rx_decoder`

## Requirements
- R1: After reset, with single-rail mode selected and the alarm-test input high, `data_o` and `aux_o` are both 0.
- R2: In single-rail mode with HDB3 off, `data_o` is 1 when the symbol sampled 3 clock edges earlier was a mark. `pos_i`=1 is a positive mark and `neg_i`=1 is a negative mark. The symbol sampled at edge n appears after edge n+3.
- R3: In single-rail mode with HDB3 off, a mark whose polarity matches the previous mark since reset drives `aux_o` high for exactly the cycle after the edge that sampled it. The first mark after reset is never flagged.
- R4: With HDB3 on, a mark whose polarity matches the previous mark is a substitution marker. It is output as 0, and so is the symbol three positions before it. An HDB3-encoded stream therefore comes out as the original bits.
- R5: With HDB3 on, a substitution marker whose polarity equals that of the previous marker raises `aux_o` for one cycle. The first marker after reset is exempt.
- R6: With HDB3 on, the fourth consecutive zero symbol raises `aux_o` for one cycle, once per run. Counting starts at reset.
- R7: In dual-rail mode with `act_low_i`=0, `data_o` is the positive rail and `aux_o` is the negative rail, both with the 3-edge latency. There is no decoding and no violation flag, and `rclk_o` follows `clk_i`.
- R8: In dual-rail mode with `act_low_i`=1, both rail outputs are inverted and `rclk_o` is the inverse of `clk_i`.
- R9: In single-rail mode, `ais_i`=1 forces `data_o` to 1 at once. `aux_o` keeps its normal behaviour.
- R10: In dual-rail mode, `ais_i`=1 forces both rail outputs to the mark level: 1 when `act_low_i`=0, 0 when `act_low_i`=1.
- R11: In single-rail mode, `alarm_test_ni`=0 forces `aux_o` to 1 and leaves `data_o` unaffected. In dual-rail mode it has no effect.
- R12: In single-rail mode, `act_low_i` is ignored: the data is not inverted and `rclk_o` follows `clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pos_i | input | 1 | Positive-rail mark |
| neg_i | input | 1 | Negative-rail mark |
| dual_rail_i | input | 1 | 1 = dual-rail, 0 = single-rail |
| hdb3_en_i | input | 1 | Enable HDB3 decoding (single-rail only) |
| act_low_i | input | 1 | Active-low outputs and inverted clock (dual-rail only) |
| ais_i | input | 1 | All-ones alarm insertion toward terminal |
| alarm_test_ni | input | 1 | Alarm test, active low |
| data_o | output | 1 | Unipolar data or positive-rail data |
| aux_o | output | 1 | Violation flag or negative-rail data |
| rclk_o | output | 1 | Receive clock toward terminal |

## Verification
A wrong polarity history would show as a spurious or missing `aux_o` pulse one cycle after the mark that exposed it. Deletion at the wrong delay-line tap would corrupt `data_o` three cycles later. Either fault would therefore be visible within four cycles of the stimulus. A zero-run counter that does not reset or saturate correctly would flag on the wrong zero, or more than once per run. Dual-rail and override faults appear at once on the combinational output stage.

// File: rtl/hdb3_rx_pkg.sv
package hdb3_rx_pkg;
  typedef struct packed {
    logic p;
    logic n;
  } rail_sym_t;

  function automatic logic sym_mark(rail_sym_t s);
    return s.p | s.n;
  endfunction

  // 1 = positive; simultaneous marks count as positive
  function automatic logic sym_pol(rail_sym_t s);
    return s.p;
  endfunction
endpackage

// File: rtl/hdb3_rx_tracker.sv
module hdb3_rx_tracker
  import hdb3_rx_pkg::*;
#(
  parameter int SUB_LEN = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  rail_sym_t sym_i,
  input  logic      hdb3_en_i,
  input  logic      dual_rail_i,
  output logic      sub_o,
  output logic      viol_o
);
  localparam int ZW = $clog2(SUB_LEN + 1);

  logic          have_mark_q, last_pol_q, have_v_q, last_v_pol_q;
  logic [ZW-1:0] zrun_q;
  logic          mark, pol, same, hdb, code_v, zero_hit;

  always_comb begin
    mark     = sym_mark(sym_i);
    pol      = sym_pol(sym_i);
    same     = mark & have_mark_q & (pol == last_pol_q);
    hdb      = hdb3_en_i & ~dual_rail_i;
    code_v   = same & have_v_q & (pol == last_v_pol_q);
    zero_hit = ~mark & (zrun_q == ZW'(SUB_LEN - 1));
    sub_o    = hdb & same;
    viol_o   = ~dual_rail_i & (hdb ? (code_v | zero_hit) : same);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_mark_q  <= 1'b0;
      last_pol_q   <= 1'b0;
      have_v_q     <= 1'b0;
      last_v_pol_q <= 1'b0;
      zrun_q       <= '0;
    end else begin
      if (mark) begin
        have_mark_q <= 1'b1;
        last_pol_q  <= pol;
        zrun_q      <= '0;
      end else if (zrun_q != ZW'(SUB_LEN)) begin
        zrun_q <= zrun_q + 1'b1;
      end
      if (same) begin
        have_v_q     <= 1'b1;
        last_v_pol_q <= pol;
      end
    end
  end

  // R6
  zrun_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zrun_q <= ZW'(SUB_LEN));

  // R3
  ami_viol_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_o && !hdb3_en_i) |-> (sym_i.p | sym_i.n));
endmodule

// File: rtl/hdb3_rx_delay.sv
module hdb3_rx_delay
  import hdb3_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  rail_sym_t sym_i,
  input  logic      kill_i,
  output rail_sym_t sym_o
);
  rail_sym_t stage_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[i] <= '0;
      end else if (i == 0) begin
        stage_q[i] <= kill_i ? rail_sym_t'('0) : sym_i;
      end else if (i == DEPTH - 1) begin
        // leading B of the code leaves the next-to-last stage here
        stage_q[i] <= kill_i ? rail_sym_t'('0) : stage_q[i-1];
      end else begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign sym_o = stage_q[DEPTH-1];
endmodule

// File: rtl/hdb3_rx_outmux.sv
module hdb3_rx_outmux
  import hdb3_rx_pkg::*;
(
  input  logic      clk_i,
  input  rail_sym_t sym_i,
  input  logic      vio_i,
  input  logic      dual_rail_i,
  input  logic      act_low_i,
  input  logic      ais_i,
  input  logic      alarm_test_ni,
  output logic      data_o,
  output logic      aux_o,
  output logic      rclk_o
);
  logic inv;

  always_comb begin
    inv = dual_rail_i & act_low_i;
    if (dual_rail_i) begin
      data_o = (ais_i | sym_i.p) ^ inv;
      aux_o  = (ais_i | sym_i.n) ^ inv;
    end else begin
      data_o = ais_i | sym_mark(sym_i);
      aux_o  = vio_i | ~alarm_test_ni;
    end
    rclk_o = clk_i ^ inv;
  end
endmodule

// File: rtl/hdb3_rx_decoder.sv
module hdb3_rx_decoder
  import hdb3_rx_pkg::*;
#(
  parameter int SUB_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_i,
  input  logic neg_i,
  input  logic dual_rail_i,
  input  logic hdb3_en_i,
  input  logic act_low_i,
  input  logic ais_i,
  input  logic alarm_test_ni,
  output logic data_o,
  output logic aux_o,
  output logic rclk_o
);
  rail_sym_t in_sym, out_sym;
  logic      sub, viol, vio_q;

  assign in_sym = '{p: pos_i, n: neg_i};

  hdb3_rx_tracker #(.SUB_LEN(SUB_LEN)) u_tracker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sym_i      (in_sym),
    .hdb3_en_i  (hdb3_en_i),
    .dual_rail_i(dual_rail_i),
    .sub_o      (sub),
    .viol_o     (viol)
  );

  hdb3_rx_delay #(.DEPTH(SUB_LEN)) u_delay (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sym_i (in_sym),
    .kill_i(sub),
    .sym_o (out_sym)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vio_q <= 1'b0;
    else         vio_q <= viol;
  end

  hdb3_rx_outmux u_outmux (
    .clk_i        (clk_i),
    .sym_i        (out_sym),
    .vio_i        (vio_q),
    .dual_rail_i  (dual_rail_i),
    .act_low_i    (act_low_i),
    .ais_i        (ais_i),
    .alarm_test_ni(alarm_test_ni),
    .data_o       (data_o),
    .aux_o        (aux_o),
    .rclk_o       (rclk_o)
  );

  // R11
  alarm_test_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dual_rail_i && !alarm_test_ni) |-> aux_o);

  // R9
  ais_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dual_rail_i && ais_i) |-> data_o);

  // R10
  ais_dual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_rail_i && ais_i) |-> (data_o == !act_low_i && aux_o == !act_low_i));

  // R7
  dual_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_rail_i && $past(dual_rail_i)) |-> !vio_q);

  // R4
  kill_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub |-> (hdb3_en_i && !dual_rail_i));
endmodule

// File: tb/hdb3_rx_decoder_tb_top.sv
module hdb3_rx_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pos = 1'b0, neg = 1'b0;
  logic dual = 1'b0, hdb = 1'b0, actl = 1'b0, ais = 1'b0, almn = 1'b1;
  logic data_o, aux_o, rclk_o;

  int n_chk = 0;
  int n_fail = 0;

  localparam int MAXN = 2100;
  bit sp [MAXN];
  bit sn [MAXN];
  bit xm [MAXN];
  bit xv [MAXN];
  bit ob [MAXN];
  bit [15:0] lf = 16'hACE1;

  always #5 clk = ~clk;

  hdb3_rx_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pos_i(pos), .neg_i(neg),
    .dual_rail_i(dual), .hdb3_en_i(hdb), .act_low_i(actl), .ais_i(ais),
    .alarm_test_ni(almn), .data_o(data_o), .aux_o(aux_o), .rclk_o(rclk_o)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic lstep();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pos = 1'b0; neg = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_sym(input int j, input int dig);
    sp[j] = (dig == 1) || (dig == 3);
    sn[j] = (dig == 2) || (dig == 3);
  endtask

  // gen: 0 exhaustive ternary, 1 random ternary, 2 random rails, 3 HDB3-encoded bits
  task automatic build(input int gen, input int n);
    int i;
    bit lastp, par;
    for (int j = 0; j < MAXN; j++) begin sp[j] = 0; sn[j] = 0; ob[j] = 0; end
    case (gen)
      0: for (int j = 0; j < n; j++) begin
           int s, p, w;
           s = j / 5; p = j % 5; w = 1;
           for (int k = 0; k < p; k++) w = w * 3;
           set_sym(j, (s / w) % 3);
         end
      1: for (int j = 0; j < n; j++) begin lstep(); set_sym(j, int'(lf % 16'd3)); end
      2: for (int j = 0; j < n; j++) begin lstep(); set_sym(j, int'(lf[1:0])); end
      default: begin
        for (int j = 0; j < n; j++) begin lstep(); ob[j] = lf[0] & lf[3]; end
        for (int j = n - 4; j < n; j++) ob[j] = 1;
        i = 0; lastp = 0; par = 0;
        while (i < n) begin
          if (i + 3 < n && !ob[i] && !ob[i+1] && !ob[i+2] && !ob[i+3]) begin
            if (par) begin
              sp[i+3] = lastp; sn[i+3] = !lastp;
            end else begin
              lastp = !lastp;
              sp[i] = lastp; sn[i] = !lastp;
              sp[i+3] = lastp; sn[i+3] = !lastp;
            end
            par = 0; i += 4;
          end else begin
            if (ob[i]) begin
              lastp = !lastp; sp[i] = lastp; sn[i] = !lastp; par = !par;
            end
            i++;
          end
        end
      end
    endcase
  endtask

  // expected marks and flags from R2..R6
  task automatic model(input int m, input bit hmode);
    bit hm = 0, lp = 0, hv = 0, lvp = 0;
    int zr = 0;
    for (int j = 0; j < m; j++) begin
      bit mk, pl, same;
      mk = sp[j] | sn[j]; pl = sp[j];
      same = mk && hm && (pl == lp);
      xm[j] = mk; xv[j] = 0;
      if (hmode) begin
        if (same) begin xm[j] = 0; if (j >= 3) xm[j-3] = 0; end
        xv[j] = (same && hv && pl == lvp) || (!mk && zr == 3);
      end else begin
        xv[j] = same;
      end
      if (mk) begin hm = 1; lp = pl; zr = 0; end else if (zr < 4) zr++;
      if (same) begin hv = 1; lvp = pl; end
    end
  endtask

  task automatic run(input int gen, input int n, input bit d_m, input bit h_m, input bit a_m,
                     input bit ais_m, input bit alm_m, input bit orig, input string rd, input string ra);
    dual = d_m; hdb = h_m; actl = a_m; ais = ais_m; almn = alm_m;
    build(gen, n);
    model(n + 4, h_m && !d_m);
    do_reset();
    for (int j = 0; j < n + 4; j++) begin
      logic ed, ea;
      if (d_m) begin
        ed = (j >= 4) ? sp[j-4] : 1'b0;
        ea = (j >= 4) ? sn[j-4] : 1'b0;
        if (ais_m) begin ed = 1'b1; ea = 1'b1; end
        ed = ed ^ a_m; ea = ea ^ a_m;
      end else begin
        if (orig) ed = (j >= 4) ? ob[j-4] : 1'b0;
        else      ed = (j >= 4) ? xm[j-4] : 1'b0;
        if (ais_m) ed = 1'b1;
        if (orig) ea = 1'b0;
        else      ea = (j >= 1) ? xv[j-1] : 1'b0;
        if (!alm_m) ea = 1'b1;
      end
      chk(rd, "data_o", data_o, ed);
      chk(ra, "aux_o", aux_o, ea);
      // clk low at the sampling point
      chk(rd, "rclk_o", rclk_o, d_m & a_m);
      pos = sp[j]; neg = sn[j];
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1", "data_o", data_o, 1'b0);
    chk("R1", "aux_o", aux_o, 1'b0);
    // R2 R3: exhaustive 5-symbol ternary, AMI
    run(0, 1215, 0, 0, 0, 0, 1, 0, "R2", "R3");
    // R4 R5 R6: random ternary with HDB3 decoding
    run(1, 900, 0, 1, 0, 0, 1, 0, "R4", "R5 R6");
    // R4: encoded stream decodes to original, no flags (R5)
    run(3, 900, 0, 1, 0, 0, 1, 1, "R4", "R5");
    // R7 R8: dual-rail both polarities
    run(2, 300, 1, 0, 0, 0, 1, 0, "R7", "R7");
    run(2, 300, 1, 1, 1, 0, 1, 0, "R8", "R8");
    // R9 single-rail all-ones, flags still live
    run(1, 300, 0, 1, 0, 1, 1, 0, "R9", "R9");
    // R10 dual-rail all-ones, both polarities
    run(2, 200, 1, 0, 0, 1, 1, 0, "R10", "R10");
    run(2, 200, 1, 0, 1, 1, 1, 0, "R10", "R10");
    // R11 alarm test: single forces flag, dual unaffected
    run(1, 300, 0, 0, 0, 0, 0, 0, "R11", "R11");
    run(2, 200, 1, 0, 0, 0, 0, 0, "R11", "R11");
    // R12 act_low ignored in single-rail
    run(0, 300, 0, 0, 1, 0, 1, 0, "R12", "R12");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule